// File: doc/BRIEF.md
# DDR1 Power-Up Configuration Sequencer

This block brings a DDR1 memory device from power-up into a configured state. After a single-cycle start request, it walks the command pins through a fixed script. First it deselects the device and idles it. It then precharges every bank, programs the extended and main mode registers and issues two refresh commands. It finishes by rewriting the extended mode register so that the device DLL stays off. After the last idle gap it raises a done flag and holds it. The memory controller can then take over the command bus.

Commands appear on the active-low strobes {cs_n, ras_n, cas_n, we_n}. Every output is a registered state decode that changes after the rising clock edge. The mode word is packed from parameters: burst length code, burst type and CAS latency code. It is issued twice, first with the DLL-reset bit set and then with it clear.

The state machine has six states:

- `ST_IDLE`: clock enable low, device deselected.
- `ST_DESEL`: one deselect with clock enable high.
- `ST_WAKE`: the opening NOP run.
- `ST_ISSUE`: one configuration command.
- `ST_GAP`: the NOP run after each configuration command.
- `ST_DONE`: finished, NOPs driven.

The transitions are:

- `IDLE→DESEL` on start.
- `DESEL→WAKE` unconditionally.
- `WAKE→ISSUE` when the wake count runs out.
- `ISSUE→GAP` unconditionally.
- `GAP→ISSUE` when the gap count runs out and steps remain.
- `GAP→DONE` when the gap count runs out on the last step.
- `DONE→DESEL` on a fresh start.

Top module: `ddr_pwrup_seq`

## Requirements
- R1: After reset, and until a start is seen, cke_o is 0, the command is DESELECT (1111), addr_o and ba_o are 0, dqm_o is all ones, and busy_o and done_o are 0.
- R2: The command is encoded as {cs_n_o, ras_n_o, cas_n_o, we_n_o}: DESELECT=1111, NOP=0111, PRECHARGE=0010, AUTO REFRESH=0001, LOAD MODE=0000. READ (0101), WRITE (0100), ACTIVE (0011) and BURST TERMINATE (0110) are never driven.
- R3: In the cycle after start is sampled, cke_o goes high and exactly one DESELECT is driven, followed by exactly five NOP cycles.
- R4: The configuration commands come in this order: PRECHARGE ALL, extended mode load, mode load with DLL reset, mode load without DLL reset, PRECHARGE ALL, AUTO REFRESH, AUTO REFRESH, extended mode load.
- R5: Each configuration command is followed by exactly four NOP cycles.
- R6: PRECHARGE ALL drives addr_o bit 10 high, all other address bits low and ba_o = 0.
- R7: A mode load uses ba_o = 00. The address packs burst length into bits 2:0, burst type into bit 3, CAS latency into bits 6:4 and DLL reset into bit 8. Bit 7 and bits 12:9 are zero. With the defaults (burst length 4 = 010, sequential = 0, CAS 2 = 010) the words are 0x122 with reset and 0x022 without.
- R8: Both extended mode loads use ba_o = 01 and addr_o = 0x001, which selects DLL disabled and normal drive.
- R9: During DESELECT and NOP cycles addr_o and ba_o are 0. dqm_o is all ones in every cycle.
- R10: busy_o is high from the DESELECT through the last NOP. In the next cycle done_o rises and then stays high with NOP driven and cke_o high. busy_o and done_o are never high together.
- R11: A start that is high while busy_o is high changes nothing in the sequence.
- R12: A start sampled while done_o is high drops done_o and replays the whole sequence from the DESELECT.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled on the rising edge |
| cke_o | output | 1 | Clock enable to the device |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| ba_o | output | 2 | Bank address |
| addr_o | output | 13 | Row / mode address bus |
| dqm_o | output | 4 | Data mask bits, held high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence finished |

## Verification
The bench compares every cycle of a run against a per-cycle expected list. It compares the command, bank, address, clock enable and the flags, so any extra or missing NOP, a swapped step or a misplaced mode bit shows up at the exact cycle. The sequence is started three ways: a clean one-cycle pulse from idle, a start held high for several cycles, and a restart from the finished state with extra pulses in mid-sequence and on the last gap cycle. The held start and the extra pulses distinguish correct ignoring while busy from a restart. The restart shows that the finished state returns to the deselect rather than resuming mid-script. Idle cycles before the first start confirm that nothing moves without a request.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

    // Command code on {cs_n, ras_n, cas_n, we_n}
    typedef enum logic [3:0] {
        CMD_DESEL = 4'b1111,
        CMD_NOP   = 4'b0111,
        CMD_BTERM = 4'b0110,
        CMD_READ  = 4'b0101,
        CMD_WRITE = 4'b0100,
        CMD_ACT   = 4'b0011,
        CMD_PRE   = 4'b0010,
        CMD_REF   = 4'b0001,
        CMD_LMR   = 4'b0000
    } ddr_cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESEL,
        ST_WAKE,
        ST_ISSUE,
        ST_GAP,
        ST_DONE
    } seq_state_e;

    // Configuration script, in issue order
    typedef enum logic [2:0] {
        STEP_PRE_FIRST,
        STEP_EXT_FIRST,
        STEP_MODE_RST,
        STEP_MODE_RUN,
        STEP_PRE_SECOND,
        STEP_REF_FIRST,
        STEP_REF_SECOND,
        STEP_EXT_FINAL
    } cfg_step_e;

    localparam cfg_step_e STEP_LAST = STEP_EXT_FINAL;

endpackage

// File: rtl/ddr_mode_word.sv
module ddr_mode_word #(
    parameter int unsigned ADDR_W   = 13,
    parameter logic [2:0]  BL_CODE  = 3'b010,
    parameter logic        BT_CODE  = 1'b0,
    parameter logic [2:0]  CL_CODE  = 3'b010,
    parameter logic        DLL_RST  = 1'b0
) (
    output logic [ADDR_W-1:0] word_o
);
    localparam int unsigned FIELD_BL  = 0;
    localparam int unsigned FIELD_BT  = 3;
    localparam int unsigned FIELD_CL  = 4;
    localparam int unsigned FIELD_RST = 8;

    localparam logic [31:0] PACKED =
          (32'(BL_CODE) << FIELD_BL)
        | (32'(BT_CODE) << FIELD_BT)
        | (32'(CL_CODE) << FIELD_CL)
        | (32'(DLL_RST) << FIELD_RST);

    assign word_o = PACKED[ADDR_W-1:0];
endmodule

// File: rtl/ddr_gap_timer.sv
module ddr_gap_timer #(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             expired_o
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/ddr_cmd_table.sv
module ddr_cmd_table
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W      = 13,
    parameter int unsigned BANK_W      = 2,
    parameter int unsigned ALL_BANK_BIT = 10,
    parameter bit          EXT_DLL_OFF = 1'b1
) (
    input  cfg_step_e          step_i,
    input  logic [ADDR_W-1:0]  mode_rst_i,
    input  logic [ADDR_W-1:0]  mode_run_i,
    output ddr_cmd_e           cmd_o,
    output logic [BANK_W-1:0]  ba_o,
    output logic [ADDR_W-1:0]  addr_o
);
    localparam logic [BANK_W-1:0] BA_MODE = BANK_W'(0);
    localparam logic [BANK_W-1:0] BA_EXT  = BANK_W'(1);
    localparam logic [ADDR_W-1:0] PRE_ALL = ADDR_W'(1) << ALL_BANK_BIT;

    logic [ADDR_W-1:0] ext_word;

    generate
        if (EXT_DLL_OFF) begin : g_dll_off
            assign ext_word = ADDR_W'(1);
        end else begin : g_dll_on
            assign ext_word = '0;
        end
    endgenerate

    always_comb begin
        cmd_o  = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        unique case (step_i)
            STEP_PRE_FIRST, STEP_PRE_SECOND: begin
                cmd_o  = CMD_PRE;
                addr_o = PRE_ALL;
            end
            STEP_EXT_FIRST, STEP_EXT_FINAL: begin
                cmd_o  = CMD_LMR;
                ba_o   = BA_EXT;
                addr_o = ext_word;
            end
            STEP_MODE_RST: begin
                cmd_o  = CMD_LMR;
                ba_o   = BA_MODE;
                addr_o = mode_rst_i;
            end
            STEP_MODE_RUN: begin
                cmd_o  = CMD_LMR;
                ba_o   = BA_MODE;
                addr_o = mode_run_i;
            end
            STEP_REF_FIRST, STEP_REF_SECOND: begin
                cmd_o  = CMD_REF;
            end
            default: begin
                cmd_o  = CMD_NOP;
            end
        endcase
    end
endmodule

// File: rtl/ddr_pwrup_seq.sv
module ddr_pwrup_seq
    import ddr_init_pkg::*;
#(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned BANK_W       = 2,
    parameter int unsigned DQM_W        = 4,
    parameter int unsigned ALL_BANK_BIT = 10,
    parameter int unsigned WAKE_NOPS    = 5,
    parameter int unsigned GAP_NOPS     = 4,
    parameter logic [2:0]  BL_CODE      = 3'b010,
    parameter logic        BT_CODE      = 1'b0,
    parameter logic [2:0]  CL_CODE      = 3'b010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              cke_o,
    output logic              cs_n_o,
    output logic              ras_n_o,
    output logic              cas_n_o,
    output logic              we_n_o,
    output logic [BANK_W-1:0] ba_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DQM_W-1:0]  dqm_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned CNT_MAX = (WAKE_NOPS > GAP_NOPS) ? WAKE_NOPS : GAP_NOPS;
    localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] WAKE_LOAD = CNT_W'(WAKE_NOPS - 1);
    localparam logic [CNT_W-1:0] GAP_LOAD  = CNT_W'(GAP_NOPS - 1);

    seq_state_e        state_q, state_d;
    cfg_step_e         step_q;
    logic              gap_over;
    logic              timer_load;
    logic [CNT_W-1:0]  timer_val;
    logic [ADDR_W-1:0] mode_rst_word, mode_run_word;
    ddr_cmd_e          tbl_cmd;
    logic [BANK_W-1:0] tbl_ba;
    logic [ADDR_W-1:0] tbl_addr;
    ddr_cmd_e          cmd;

    // Mode words: one with the DLL-reset bit, one without
    ddr_mode_word #(
        .ADDR_W (ADDR_W), .BL_CODE(BL_CODE), .BT_CODE(BT_CODE),
        .CL_CODE(CL_CODE), .DLL_RST(1'b1)
    ) u_mode_rst (
        .word_o (mode_rst_word)
    );

    ddr_mode_word #(
        .ADDR_W (ADDR_W), .BL_CODE(BL_CODE), .BT_CODE(BT_CODE),
        .CL_CODE(CL_CODE), .DLL_RST(1'b0)
    ) u_mode_run (
        .word_o (mode_run_word)
    );

    ddr_cmd_table #(
        .ADDR_W      (ADDR_W),
        .BANK_W      (BANK_W),
        .ALL_BANK_BIT(ALL_BANK_BIT),
        .EXT_DLL_OFF (1'b1)
    ) u_table (
        .step_i     (step_q),
        .mode_rst_i (mode_rst_word),
        .mode_run_i (mode_run_word),
        .cmd_o      (tbl_cmd),
        .ba_o       (tbl_ba),
        .addr_o     (tbl_addr)
    );

    // NOP run length: loaded on the deselect and on each command
    assign timer_load = (state_q == ST_DESEL) || (state_q == ST_ISSUE);
    assign timer_val  = (state_q == ST_DESEL) ? WAKE_LOAD : GAP_LOAD;

    ddr_gap_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (timer_load),
        .load_val_i (timer_val),
        .expired_o  (gap_over)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Script position
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q <= STEP_PRE_FIRST;
        end else if (state_q == ST_DESEL) begin
            step_q <= STEP_PRE_FIRST;
        end else if (state_q == ST_GAP && gap_over && step_q != STEP_LAST) begin
            step_q <= cfg_step_e'(step_q + 3'd1);
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)  state_d = ST_DESEL;
            ST_DESEL: state_d = ST_WAKE;
            ST_WAKE:  if (gap_over) state_d = ST_ISSUE;
            ST_ISSUE: state_d = ST_GAP;
            ST_GAP: begin
                if (gap_over) begin
                    state_d = (step_q == STEP_LAST) ? ST_DONE : ST_ISSUE;
                end
            end
            ST_DONE:  if (start_i)  state_d = ST_DESEL;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Outputs, decoded from the registered state
    always_comb begin
        cke_o  = 1'b1;
        cmd    = CMD_NOP;
        ba_o   = '0;
        addr_o = '0;
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                cke_o  = 1'b0;
                cmd    = CMD_DESEL;
                busy_o = 1'b0;
            end
            ST_DESEL: cmd = CMD_DESEL;
            ST_WAKE:  cmd = CMD_NOP;
            ST_ISSUE: begin
                cmd    = tbl_cmd;
                ba_o   = tbl_ba;
                addr_o = tbl_addr;
            end
            ST_GAP:   cmd = CMD_NOP;
            ST_DONE: begin
                busy_o = 1'b0;
                done_o = 1'b1;
            end
            default: begin
                cke_o  = 1'b0;
                cmd    = CMD_DESEL;
                busy_o = 1'b0;
            end
        endcase
    end

    assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd;
    assign dqm_o = '1;

endmodule

// File: rtl/ddr_pwrup_seq_chk.sv
module ddr_pwrup_seq_chk #(
    parameter int unsigned ADDR_W       = 13,
    parameter int unsigned BANK_W       = 2,
    parameter int unsigned ALL_BANK_BIT = 10,
    parameter logic [2:0]  CL_CODE      = 3'b010
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cke_o,
    input logic              cs_n_o,
    input logic              ras_n_o,
    input logic              cas_n_o,
    input logic              we_n_o,
    input logic [BANK_W-1:0] ba_o,
    input logic [ADDR_W-1:0] addr_o,
    input logic              busy_o,
    input logic              done_o
);
    logic [3:0] c;
    logic       idle_cmd;
    assign c        = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
    assign idle_cmd = (c == 4'b0111) || (c == 4'b1111);

    assert_no_data_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(c inside {4'b0101, 4'b0100, 4'b0011, 4'b0110}));

    assert_start_desel_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (c == 4'b1111) && cke_o);

    assert_cfg_then_nop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !idle_cmd) |=> (c == 4'b0111));

    assert_pre_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0010) |-> addr_o[ALL_BANK_BIT] && (ba_o == '0));

    assert_mode_fields_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0000 && ba_o == '0) |->
            (addr_o[7] == 1'b0) && (addr_o[ADDR_W-1:9] == '0) && (addr_o[6:4] == CL_CODE));

    assert_ext_dll_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (c == 4'b0000 && ba_o == BANK_W'(1)) |-> (addr_o == ADDR_W'(1)));

    assert_quiet_bus_R9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_cmd |-> (addr_o == '0) && (ba_o == '0));

    assert_flag_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && done_o));

    assert_done_after_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> ($past(c) == 4'b0111) && $past(busy_o));

    assert_busy_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (busy_o || done_o));

endmodule

bind ddr_pwrup_seq ddr_pwrup_seq_chk #(
    .ADDR_W      (ADDR_W),
    .BANK_W      (BANK_W),
    .ALL_BANK_BIT(ALL_BANK_BIT),
    .CL_CODE     (CL_CODE)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cke_o   (cke_o),
    .cs_n_o  (cs_n_o),
    .ras_n_o (ras_n_o),
    .cas_n_o (cas_n_o),
    .we_n_o  (we_n_o),
    .ba_o    (ba_o),
    .addr_o  (addr_o),
    .busy_o  (busy_o),
    .done_o  (done_o)
);

// File: tb/tb_ddr_pwrup_seq.sv
module tb_ddr_pwrup_seq;

    // Command codes on {cs_n, ras_n, cas_n, we_n} (R2)
    localparam logic [3:0] E_DESEL = 4'b1111;
    localparam logic [3:0] E_NOP   = 4'b0111;
    localparam logic [3:0] E_PRE   = 4'b0010;
    localparam logic [3:0] E_REF   = 4'b0001;
    localparam logic [3:0] E_LMR   = 4'b0000;

    typedef struct {
        logic [3:0]  cmd;
        logic [1:0]  ba;
        logic [12:0] addr;
        logic        cke;
        logic        busy;
        logic        done;
        string       req;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        cke_o, cs_n_o, ras_n_o, cas_n_o, we_n_o, busy_o, done_o;
    logic [1:0]  ba_o;
    logic [12:0] addr_o;
    logic [3:0]  dqm_o;

    int    total = 0;
    int    bad = 0;
    int    cyc = 0;
    string ctx = "R1";
    exp_t  q[$];

    always #10 clk = ~clk;

    ddr_pwrup_seq dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .cke_o(cke_o), .cs_n_o(cs_n_o), .ras_n_o(ras_n_o), .cas_n_o(cas_n_o),
        .we_n_o(we_n_o), .ba_o(ba_o), .addr_o(addr_o), .dqm_o(dqm_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    task automatic push(input logic [3:0] c, input logic [1:0] b, input logic [12:0] a,
                        input logic k, input logic bz, input logic dn, input string r);
        exp_t e;
        e.cmd = c; e.ba = b; e.addr = a; e.cke = k; e.busy = bz; e.done = dn; e.req = r;
        q.push_back(e);
    endtask

    task automatic push_gap();
        for (int i = 0; i < 4; i++) push(E_NOP, 2'd0, 13'h0, 1'b1, 1'b1, 1'b0, "R5");
    endtask

    // Full expected script, one entry per cycle
    task automatic push_script();
        push(E_DESEL, 2'd0, 13'h0, 1'b1, 1'b1, 1'b0, "R3");
        for (int i = 0; i < 5; i++) push(E_NOP, 2'd0, 13'h0, 1'b1, 1'b1, 1'b0, "R3");
        push(E_PRE, 2'd0, 13'h400, 1'b1, 1'b1, 1'b0, "R6 R4"); push_gap();
        push(E_LMR, 2'd1, 13'h001, 1'b1, 1'b1, 1'b0, "R8 R4"); push_gap();
        push(E_LMR, 2'd0, 13'h122, 1'b1, 1'b1, 1'b0, "R7 R4"); push_gap();
        push(E_LMR, 2'd0, 13'h022, 1'b1, 1'b1, 1'b0, "R7 R4"); push_gap();
        push(E_PRE, 2'd0, 13'h400, 1'b1, 1'b1, 1'b0, "R6 R4"); push_gap();
        push(E_REF, 2'd0, 13'h000, 1'b1, 1'b1, 1'b0, "R4");    push_gap();
        push(E_REF, 2'd0, 13'h000, 1'b1, 1'b1, 1'b0, "R4");    push_gap();
        push(E_LMR, 2'd1, 13'h001, 1'b1, 1'b1, 1'b0, "R8 R4"); push_gap();
        for (int i = 0; i < 3; i++) push(E_NOP, 2'd0, 13'h0, 1'b1, 1'b0, 1'b1, "R10");
    endtask

    task automatic wait_empty();
        while (q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    // Monitor: pops one expected entry per cycle and compares
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            total++;
            if ({cs_n_o, ras_n_o, cas_n_o, we_n_o} inside {4'b0101, 4'b0100, 4'b0011, 4'b0110}) begin
                bad++;
                $display("FAIL R2 cyc %0d: data command %b, expected none", cyc,
                         {cs_n_o, ras_n_o, cas_n_o, we_n_o});
            end
            total++;
            if (dqm_o !== 4'hF) begin
                bad++;
                $display("FAIL R9 cyc %0d: dqm=%h expected f", cyc, dqm_o);
            end
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                total++;
                if ({cs_n_o, ras_n_o, cas_n_o, we_n_o} !== e.cmd || ba_o !== e.ba ||
                    addr_o !== e.addr || cke_o !== e.cke || busy_o !== e.busy ||
                    done_o !== e.done) begin
                    bad++;
                    $display("FAIL %s (%s) cyc %0d: got cmd=%b ba=%0d addr=%h cke=%b busy=%b done=%b, expected cmd=%b ba=%0d addr=%h cke=%b busy=%b done=%b",
                             e.req, ctx, cyc, {cs_n_o, ras_n_o, cas_n_o, we_n_o}, ba_o, addr_o,
                             cke_o, busy_o, done_o, e.cmd, e.ba, e.addr, e.cke, e.busy, e.done);
                end
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Driver
    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: idle with no start
        @(posedge clk);
        for (int i = 0; i < 4; i++) push(E_DESEL, 2'd0, 13'h0, 1'b0, 1'b0, 1'b0, "R1");
        wait_empty();

        // Run 1: clean single-cycle pulse from idle
        ctx = "pulse R3";
        @(negedge clk); start_i = 1'b1;
        @(posedge clk); push_script();
        @(negedge clk); start_i = 1'b0;
        wait_empty();

        // Run 2: restart from done (R12) with start held and re-pulsed while busy (R11)
        ctx = "R12 restart, R11 extra starts";
        @(negedge clk); start_i = 1'b1;
        @(posedge clk); push_script();
        repeat (3) @(negedge clk);
        start_i = 1'b0;
        repeat (17) @(negedge clk);
        start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
        repeat (25) @(negedge clk);
        start_i = 1'b1;               // sampled on the last gap NOP
        @(negedge clk); start_i = 1'b0;
        wait_empty();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule